// File: doc/BRIEF.md
# Contactless Frame Serializer

This block converts a stream of bytes into the framed serial bit stream a proximity card reader sends to a card, at one elementary time unit (ETU) per bit. A frame opens with a start-of-frame pattern: a run of zeros followed by a short run of ones. The data characters come next, each with its own start and stop bit and with optional guard ETUs between characters. When enabled, two CRC bytes are appended. The frame closes with a run of zeros as its end-of-frame pattern. Subcarrier modulation and reception are handled elsewhere.

Bytes arrive on a valid/ready handshake with a last-byte flag. A valid byte seen while the block is idle starts a frame. The rate setting, the run lengths, the guard count and the CRC switch are latched when the frame starts. A registered loopback tap can feed the transmit line back toward the receive path for a power-on self test.

Top module: `nfc_tx_framer`

## Requirements
- R1: The ETU is ETU_BASE clock cycles for rate code 00, ETU_BASE/2 for code 01, and ETU_BASE/4 for both 10 and 11. The rate and every framing control are latched at frame start, so changing them mid-frame has no effect on that frame.
- R2: After reset and between frames, ser_out is 1, busy is 0 and in_ready is 0.
- R3: The frame begins with a zero run of 10 ETUs when sof_zero_ext is 0, or 11 ETUs when it is 1.
- R4: The zero run of the start of frame is followed by a one run of 2 ETUs when sof_one_ext is 0, or 3 ETUs when it is 1.
- R5: Each character is a 0 start bit, then eight data bits least significant first, then a 1 stop bit.
- R6: Between two consecutive characters (data or CRC), guard_etus extra ETUs of 1 are sent. None are sent after the start of frame or before the end of frame.
- R7: When crc_off is 0, two characters follow the last data byte. They carry the ones' complement of a CRC-16 computed over the data bytes only (reflected polynomial 0x8408, preset 0xFFFF), low byte first. When crc_off is 1, no CRC is sent.
- R8: The frame ends with a zero run of 10 ETUs when eof_zero_ext is 0, or 11 ETUs when it is 1. ser_out then returns to 1 and busy drops, so busy has been high for exactly the frame length in ETUs times the ETU period.
- R9: in_ready is high only in the last cycle of the start of frame, in the last cycle of a stop bit or guard time that precedes another data byte, or while waiting for a byte. A frame is started by in_valid while idle without consuming the byte. An accepted byte's start bit appears on ser_out in the next cycle.
- R10: If no byte is offered when one is due and the last byte has not yet been taken, ser_out is held at 1 and busy stays high until a byte arrives.
- R11: rx_out is a one-cycle-delayed copy of ser_out when loop_en is 1, and of rx_in when loop_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 2 | Bit rate code, latched at frame start |
| sof_zero_ext | input | 1 | Lengthens the start-of-frame zero run to 11 ETUs |
| sof_one_ext | input | 1 | Lengthens the start-of-frame one run to 3 ETUs |
| eof_zero_ext | input | 1 | Lengthens the end-of-frame zero run to 11 ETUs |
| guard_etus | input | GUARD_W | Extra ETUs between characters |
| crc_off | input | 1 | Suppresses the CRC characters |
| loop_en | input | 1 | Selects ser_out as the source of rx_out |
| rx_in | input | 1 | Receive line from outside |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | in_data is valid |
| in_last | input | 1 | in_data is the last byte of the frame |
| in_ready | output | 1 | The byte on in_data is taken this cycle if valid |
| ser_out | output | 1 | Serial transmit line |
| busy | output | 1 | Frame in progress |
| rx_out | output | 1 | Receive path after the loopback selector |

## Verification
ser_out and busy are registers, so each changes on the first clock edge after the event that causes it. The start-of-frame zero appears one cycle after in_valid is seen idle, and a start bit appears one cycle after its byte is accepted. Every later bit lasts exactly one ETU of cycles. The bench therefore starts an ETU cycle count at the first negative edge where busy is high, samples ser_out at the middle of each ETU, and compares the result bit for bit against a frame built from the requirements. It also compares the total busy time against the expected ETU count. rx_out is compared at every negative edge against the value ser_out or rx_in had one cycle earlier.

// File: rtl/nfc_tx_pkg.sv
package nfc_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SOF0,
    ST_SOF1,
    ST_CHAR,
    ST_GUARD,
    ST_WAIT,
    ST_EOF
  } seq_state_t;

  localparam logic [15:0] CRC_POLY_R = 16'h8408;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;

  // One byte of the reflected CRC-16, bit by bit, LSB of the byte first.
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {8'h00, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_R) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/etu_timer.sv
module etu_timer #(
  parameter int ETU_BASE = 128
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       sync,
  input  logic [1:0] rate,
  output logic       tick
);
  localparam int CW = $clog2(ETU_BASE);

  logic [1:0]    rate_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb begin
    if (rate_q[1])      lim = CW'((ETU_BASE >> 2) - 1);
    else if (rate_q[0]) lim = CW'((ETU_BASE >> 1) - 1);
    else                lim = CW'(ETU_BASE - 1);
  end

  assign tick = (cnt == lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      rate_q <= 2'b00;
      cnt    <= '0;
    end else begin
      if (load) rate_q <= rate;
      if (sync || tick) cnt <= '0;
      else              cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/crc16_acc.sv
module crc16_acc
  import nfc_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  data,
  output logic [15:0] crc
);
  always_ff @(posedge clk) begin
    if (rst || clr) crc <= CRC_PRESET;
    else if (en)    crc <= crc16_step(crc, data);
  end
endmodule

// File: rtl/frame_seq.sv
module frame_seq
  import nfc_tx_pkg::*;
#(
  parameter int GUARD_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               sof_zero_ext,
  input  logic               sof_one_ext,
  input  logic               eof_zero_ext,
  input  logic [GUARD_W-1:0] guard_etus,
  input  logic               crc_off,
  input  logic [7:0]         in_data,
  input  logic               in_valid,
  input  logic               in_last,
  input  logic [15:0]        crc_q,
  output logic               in_ready,
  output logic               ser_out,
  output logic               busy,
  output logic               t_load,
  output logic               t_sync,
  output logic               crc_clr,
  output logic               crc_en
);
  localparam int CNTW = (GUARD_W > 4) ? GUARD_W : 4;

  seq_state_t         st;
  logic [CNTW-1:0]    cnt;
  logic [9:0]         sh;
  logic               s0x_q, s1x_q, ex_q, coff_q;
  logic [GUARD_W-1:0] guard_q;
  logic               last_seen;
  logic [1:0]         crc_left;

  logic            start, accept, more, adv_next, take;
  logic [CNTW-1:0] z_end, o_end, e_end, g_end;
  logic [7:0]      nb;

  assign z_end = s0x_q ? CNTW'(10) : CNTW'(9);
  assign o_end = s1x_q ? CNTW'(2)  : CNTW'(1);
  assign e_end = ex_q  ? CNTW'(10) : CNTW'(9);
  assign g_end = CNTW'(guard_q) - 1'b1;

  assign more  = !last_seen || (crc_left != 2'd0);
  assign start = (st == ST_IDLE) && in_valid;

  always_comb begin
    adv_next = 1'b0;
    if (tick) begin
      unique case (st)
        ST_SOF1:  adv_next = (cnt == o_end);
        ST_GUARD: adv_next = (cnt == g_end);
        ST_CHAR:  adv_next = (cnt == CNTW'(9)) && more && (guard_q == '0);
        default:  adv_next = 1'b0;
      endcase
    end
  end

  assign in_ready = (st == ST_WAIT) || (adv_next && !last_seen);
  assign accept   = in_ready && in_valid;
  assign take     = accept || (adv_next && last_seen);
  assign nb       = !last_seen ? in_data
                  : (crc_left == 2'd2) ? ~crc_q[7:0] : ~crc_q[15:8];

  assign t_load  = start;
  assign t_sync  = start || ((st == ST_WAIT) && in_valid);
  assign crc_clr = start;
  assign crc_en  = accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      ser_out   <= 1'b1;
      busy      <= 1'b0;
      s0x_q     <= 1'b0;
      s1x_q     <= 1'b0;
      ex_q      <= 1'b0;
      coff_q    <= 1'b0;
      guard_q   <= '0;
      last_seen <= 1'b0;
      crc_left  <= 2'd0;
    end else begin
      if (accept) begin
        last_seen <= in_last;
        crc_left  <= (in_last && !coff_q) ? 2'd2 : 2'd0;
      end
      unique case (st)
        ST_IDLE: if (in_valid) begin
          st        <= ST_SOF0;
          ser_out   <= 1'b0;
          busy      <= 1'b1;
          cnt       <= '0;
          s0x_q     <= sof_zero_ext;
          s1x_q     <= sof_one_ext;
          ex_q      <= eof_zero_ext;
          coff_q    <= crc_off;
          guard_q   <= guard_etus;
          last_seen <= 1'b0;
          crc_left  <= 2'd0;
        end
        ST_SOF0: if (tick) begin
          if (cnt == z_end) begin
            st      <= ST_SOF1;
            ser_out <= 1'b1;
            cnt     <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_SOF1: if (tick && !adv_next) cnt <= cnt + 1'b1;
        ST_CHAR: if (tick) begin
          if (cnt == CNTW'(9)) begin
            if (!more) begin
              st      <= ST_EOF;
              ser_out <= 1'b0;
              cnt     <= '0;
            end else if (guard_q != '0) begin
              st  <= ST_GUARD;
              cnt <= '0;
            end
          end else begin
            cnt     <= cnt + 1'b1;
            sh      <= sh >> 1;
            ser_out <= sh[1];
          end
        end
        ST_GUARD: if (tick && !adv_next) cnt <= cnt + 1'b1;
        ST_WAIT: ;
        ST_EOF: if (tick) begin
          if (cnt == e_end) begin
            st      <= ST_IDLE;
            ser_out <= 1'b1;
            busy    <= 1'b0;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
      if (adv_next && !take) begin
        st      <= ST_WAIT;
        ser_out <= 1'b1;
      end
      if (take) begin
        st      <= ST_CHAR;
        cnt     <= '0;
        sh      <= {1'b1, nb, 1'b0};
        ser_out <= 1'b0;
        if (last_seen) crc_left <= crc_left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/nfc_tx_framer.sv
module nfc_tx_framer #(
  parameter int ETU_BASE = 128,
  parameter int GUARD_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         rate_sel,
  input  logic               sof_zero_ext,
  input  logic               sof_one_ext,
  input  logic               eof_zero_ext,
  input  logic [GUARD_W-1:0] guard_etus,
  input  logic               crc_off,
  input  logic               loop_en,
  input  logic               rx_in,
  input  logic [7:0]         in_data,
  input  logic               in_valid,
  input  logic               in_last,
  output logic               in_ready,
  output logic               ser_out,
  output logic               busy,
  output logic               rx_out
);
  logic        tick, t_load, t_sync, crc_clr, crc_en;
  logic [15:0] crc_q;

  etu_timer #(.ETU_BASE(ETU_BASE)) u_etu (
    .clk(clk), .rst(rst), .load(t_load), .sync(t_sync), .rate(rate_sel), .tick(tick)
  );

  crc16_acc u_crc (
    .clk(clk), .rst(rst), .clr(crc_clr), .en(crc_en), .data(in_data), .crc(crc_q)
  );

  frame_seq #(.GUARD_W(GUARD_W)) u_seq (
    .clk(clk), .rst(rst), .tick(tick),
    .sof_zero_ext(sof_zero_ext), .sof_one_ext(sof_one_ext), .eof_zero_ext(eof_zero_ext),
    .guard_etus(guard_etus), .crc_off(crc_off),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last), .crc_q(crc_q),
    .in_ready(in_ready), .ser_out(ser_out), .busy(busy),
    .t_load(t_load), .t_sync(t_sync), .crc_clr(crc_clr), .crc_en(crc_en)
  );

  // Self-test tap: registered selector between the outgoing line and the external receive line.
  always_ff @(posedge clk) begin
    if (rst) rx_out <= 1'b1;
    else     rx_out <= loop_en ? ser_out : rx_in;
  end
endmodule

// File: rtl/nfc_tx_framer_chk.sv
module nfc_tx_framer_chk (
  input logic clk,
  input logic rst,
  input logic ser_out,
  input logic busy,
  input logic in_valid,
  input logic in_ready,
  input logic loop_en,
  input logic rx_in,
  input logic rx_out
);
  a_r2_idle_line_high: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ser_out);

  a_r3_sof_opens_low: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !ser_out);

  a_r8_eof_closes_low: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (!$past(ser_out) && ser_out));

  a_r9_ready_only_in_frame: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> busy);

  a_r5_start_bit_follows_accept: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !ser_out);

  a_r11_loop_copy: assert property (@(posedge clk) disable iff (rst)
    $past(loop_en) |-> (rx_out == $past(ser_out)));

  a_r11_direct_copy: assert property (@(posedge clk) disable iff (rst)
    !$past(loop_en) |-> (rx_out == $past(rx_in)));
endmodule

bind nfc_tx_framer nfc_tx_framer_chk u_chk (
  .clk(clk), .rst(rst), .ser_out(ser_out), .busy(busy), .in_valid(in_valid),
  .in_ready(in_ready), .loop_en(loop_en), .rx_in(rx_in), .rx_out(rx_out)
);

// File: tb/tb_nfc_tx_framer.sv
module tb_nfc_tx_framer;
  localparam int EB = 8;
  localparam int GW = 4;
  localparam int NV = 6;

  // {rate[1:0], sof0x, sof1x, eofx, crc_off, guard[3:0], nbytes[2:0], bytes[31:0] (byte0 lowest)}
  localparam logic [44:0] VECS [0:NV-1] = '{
    {2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 4'd0,  3'd3, 32'h0056_3412},
    {2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd2,  3'd2, 32'h0000_0FA5},
    {2'd2, 1'b0, 1'b1, 1'b0, 1'b1, 4'd1,  3'd4, 32'h0180_00FF},
    {2'd3, 1'b1, 1'b0, 1'b1, 1'b0, 4'd3,  3'd1, 32'h0000_00C3},
    {2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0,  3'd1, 32'h0000_007E},
    {2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd15, 3'd2, 32'h0000_AA55}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    rate_sel = 2'd0;
  logic          sof_zero_ext = 1'b0, sof_one_ext = 1'b0, eof_zero_ext = 1'b0;
  logic [GW-1:0] guard_etus = '0;
  logic          crc_off = 1'b0, loop_en = 1'b0, rx_in = 1'b1;
  logic [7:0]    in_data = 8'h00;
  logic          in_valid = 1'b0, in_last = 1'b0;
  logic          in_ready, ser_out, busy, rx_out;

  int n_chk = 0;
  int n_bad = 0;

  bit exp_bits [0:1023];
  int exp_n;
  bit got_bits [0:1023];

  bit lchk = 1'b0;
  bit prev_ser;
  int lerr = 0;

  always #4 clk = ~clk;

  nfc_tx_framer #(.ETU_BASE(EB), .GUARD_W(GW)) dut (
    .clk(clk), .rst(rst), .rate_sel(rate_sel), .sof_zero_ext(sof_zero_ext),
    .sof_one_ext(sof_one_ext), .eof_zero_ext(eof_zero_ext), .guard_etus(guard_etus),
    .crc_off(crc_off), .loop_en(loop_en), .rx_in(rx_in), .in_data(in_data),
    .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready), .ser_out(ser_out),
    .busy(busy), .rx_out(rx_out)
  );

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R11 monitor: rx_out against ser_out one cycle earlier
  always @(negedge clk) begin
    if (lchk && (rx_out !== prev_ser)) lerr++;
    prev_ser = ser_out;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  function automatic int etu_of(input logic [1:0] r);
    return r[1] ? EB / 4 : (r[0] ? EB / 2 : EB);
  endfunction

  function automatic logic [15:0] ref_crc(input int n, input logic [31:0] b);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {8'h00, b[8*i +: 8]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    end
    return c;
  endfunction

  task automatic push(input bit v);
    exp_bits[exp_n] = v;
    exp_n++;
  endtask

  // Expected frame from R3..R8
  task automatic build(input logic [44:0] v);
    int n, g, nch;
    logic [15:0] c;
    logic [7:0] ch;
    n = int'(v[34:32]);
    g = int'(v[38:35]);
    c = ~ref_crc(n, v[31:0]);
    nch = n + (v[39] ? 0 : 2);
    exp_n = 0;
    repeat (v[42] ? 11 : 10) push(1'b0);
    repeat (v[41] ? 3 : 2) push(1'b1);
    for (int k = 0; k < nch; k++) begin
      if (k > 0) repeat (g) push(1'b1);
      ch = (k < n) ? v[8*k +: 8] : ((k == n) ? c[7:0] : c[15:8]);
      push(1'b0);
      for (int j = 0; j < 8; j++) push(ch[j]);
      push(1'b1);
    end
    repeat (v[40] ? 11 : 10) push(1'b0);
  endtask

  task automatic drive_bytes(input int n, input logic [31:0] b);
    int idx = 0;
    bit hs;
    in_data  = b[7:0];
    in_last  = (n == 1);
    in_valid = 1'b1;
    while (idx < n) begin
      @(negedge clk);
      hs = in_valid && in_ready;
      @(posedge clk);
      #1;
      if (hs) begin
        idx++;
        if (idx < n) begin
          in_data = b[8*idx +: 8];
          in_last = (idx == n - 1);
        end else in_valid = 1'b0;
      end
    end
  endtask

  task automatic run_frame(input logic [44:0] v, input bit chg_mid, input string tag);
    int e, k, cyc, bad_at;
    e = etu_of(v[44:43]);
    rate_sel = v[44:43];
    sof_zero_ext = v[42];
    sof_one_ext = v[41];
    eof_zero_ext = v[40];
    crc_off = v[39];
    guard_etus = v[38:35];
    build(v);
    k = 0;
    cyc = 0;
    fork
      drive_bytes(int'(v[34:32]), v[31:0]);
      begin
        @(negedge clk);
        while (!busy) @(negedge clk);
        while (busy) begin
          if ((cyc % e) == e / 2) begin
            if (k < 1024) got_bits[k] = ser_out;
            k++;
          end
          cyc++;
          @(negedge clk);
        end
      end
      if (chg_mid) begin
        @(negedge clk);
        while (!busy) @(negedge clk);
        repeat (3) @(posedge clk);
        #1;
        rate_sel = 2'd2;
        sof_zero_ext = ~sof_zero_ext;
        eof_zero_ext = ~eof_zero_ext;
        crc_off = ~crc_off;
        guard_etus = guard_etus + 4'd3;
      end
    join
    bad_at = -1;
    for (int i = 0; i < exp_n && i < k; i++)
      if (bad_at < 0 && got_bits[i] != exp_bits[i]) bad_at = i;
    chk(k == exp_n, tag, "frame length in ETUs (R3 R4 R6 R7 R8)", k, exp_n);
    chk(bad_at < 0, tag, "first wrong bit index (R5 R6 R7)", bad_at, -1);
    chk(cyc == exp_n * e, tag, "busy cycles, ETU period (R1 R8)", cyc, exp_n * e);
    chk(ser_out == 1'b1, tag, "line after frame (R8)", int'(ser_out), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk(ser_out == 1'b1, "R2", "ser_out after reset", int'(ser_out), 1);
    chk(busy == 1'b0, "R2", "busy after reset", int'(busy), 0);
    chk(in_ready == 1'b0, "R2", "in_ready after reset", int'(in_ready), 0);

    // vector table; loopback monitored during the first entry (R11)
    for (int i = 0; i < NV; i++) begin
      if (i == 0) begin
        loop_en = 1'b1;
        rx_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        lerr = 0;
        lchk = 1'b1;
      end
      run_frame(VECS[i], 1'b0, $sformatf("vec%0d", i));
      if (i == 0) begin
        lchk = 1'b0;
        chk(lerr == 0, "R11", "loopback mismatches", lerr, 0);
        loop_en = 1'b0;
      end
      repeat (3) @(negedge clk);
    end

    // R11: external line selected when loopback off
    rx_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(rx_out == 1'b0, "R11", "rx_out follows rx_in low", int'(rx_out), 0);
    rx_in = 1'b1;
    @(negedge clk);
    chk(rx_out == 1'b1, "R11", "rx_out follows rx_in high", int'(rx_out), 1);

    // R1: controls changed mid-frame have no effect
    run_frame({2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd1, 3'd2, 32'h0000_9C31}, 1'b1, "R1 latch");
    repeat (3) @(negedge clk);

    // R10 / R9: stall between bytes
    rate_sel = 2'd2;
    guard_etus = '0;
    crc_off = 1'b1;
    sof_zero_ext = 1'b0;
    sof_one_ext = 1'b0;
    eof_zero_ext = 1'b0;
    in_data = 8'h3C;
    in_last = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    while (!(in_valid && in_ready)) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
    repeat (60) @(negedge clk);
    chk(busy == 1'b1, "R10", "busy during stall", int'(busy), 1);
    chk(ser_out == 1'b1, "R10", "line during stall", int'(ser_out), 1);
    chk(in_ready == 1'b1, "R9", "ready while waiting", int'(in_ready), 1);
    #1;
    in_data = 8'h81;
    in_last = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    while (!(in_valid && in_ready)) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
    @(negedge clk);
    chk(ser_out == 1'b0, "R9", "start bit one cycle after accept", int'(ser_out), 0);
    while (busy) @(negedge clk);
    chk(ser_out == 1'b1, "R10", "line after resumed frame", int'(ser_out), 1);
    chk(in_ready == 1'b0, "R2", "in_ready idle after frame", int'(in_ready), 0);

    finish_run();
  end
endmodule